// File: doc/BRIEF.md
# Banked Scratchpad Back End with Lane Collector

This block forms the storage and return path of a multi-lane scratchpad. Each cycle it may accept one issue set. An issue set carries, for every lane, a bank number, an entry offset, a write word, a byte mask and an enable bit. One store flag and one last-issue marker are shared by all lanes. An upstream stage has already mapped the addresses and split conflicting requests. Within one issue set, every enabled lane therefore targets a different bank, or shares a bank and offset with other lanes for a broadcast read.

An input crossbar steers each enabled lane to the bank it names, and the enabled lanes act as the bank enables. The banks have one port and a one-cycle read latency, with byte-granular writes. An output crossbar returns each bank word to every lane that asked for it. A set of per-lane collector registers gathers results from several serialized issue sets into one output vector. A valid pulse marks the moment the last issue set of a request has been collected.

The configuration lives in the package: lanes L=4, banks B=4, entries per bank D=16, bytes per word 4. Words are 32 bits and memory is addressed per byte.

Top module: `lane_bank_gather`

## Requirements
- R1: A store writes only the bytes whose mask bit is set. Mask bit k of a lane covers bits [8k+7:8k] of its 32-bit word. The other bytes of the entry keep their value.
- R2: An enabled lane's request reaches bank `laneBank` of that lane at entry `laneOff`. Lane i uses `laneBank[2i+1:2i]`, `laneOff[4i+3:4i]`, `laneData[32i+31:32i]` and `laneMask[4i+3:4i]`.
- R3: A lane whose `laneEn` bit is 0 writes nothing. Its collector entry keeps its previous value.
- R4: For a load issued in cycle t, the data appears on `outData` after the second rising edge following t. It stays there until that lane is loaded again.
- R5: Several enabled lanes that name the same bank and offset in a load all receive that entry's word.
- R6: `outValid` is high for exactly one cycle for each accepted issue set with `issueLast`=1. It rises with the same latency as R4. Issue sets without the marker never raise it.
- R7: Results from serialized issue sets that belong to one request accumulate in the collector. Lanes filled by an earlier issue set keep their data while later issue sets fill other lanes.
- R8: A store issue set with `issueLast`=1 still pulses `outValid`. It leaves every collector entry unchanged.
- R9: While `rst_n` is low, `outValid` is 0 and `outData` is all zeros.
- R10: Issue sets may arrive in consecutive cycles. A load issued in the cycle right after a store to the same entry returns the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An issue set is presented this cycle |
| issueStore | input | 1 | 1 = store issue set, 0 = load |
| issueLast | input | 1 | Final issue set of a request |
| laneEn | input | 4 | Per-lane participation bit |
| laneBank | input | 8 | Per-lane bank number, 2 bits per lane |
| laneOff | input | 16 | Per-lane entry offset within the bank, 4 bits per lane |
| laneData | input | 128 | Per-lane write word, 32 bits per lane |
| laneMask | input | 16 | Per-lane byte write mask, 4 bits per lane |
| outValid | output | 1 | One-cycle pulse when a request is complete |
| outData | output | 128 | Collector contents, 32 bits per lane |

## Verification
The bench targets byte masks that mix set and clear bits. A design that ignored the mask would overwrite neighbouring bytes. It also targets lanes disabled in the middle of a store and of a load: a wrong design would write stray data or clear collector slots. Broadcast loads, in which every lane reads one entry, catch an output crossbar that delivers the word to only one lane. Serialized requests split over two issue sets, stores immediately followed by loads of the same entry, and non-final issue sets expose a misaligned read pipeline. They also expose a valid pulse that fires early, too often, or not at all for stores.

// File: rtl/spmbc_pkg.sv
package spmbc_pkg;
  parameter int LANES = 4;
  parameter int BANKS = 4;
  parameter int DEPTH = 16;
  parameter int BYTES = 4;

  localparam int DATAW = BYTES * 8;
  localparam int LIDX  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BIDX  = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int OFFW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [BANKS-1:0]           bankEn;   // bank accessed this cycle
    logic [BANKS-1:0]           bankWr;   // bank written this cycle
    logic [BANKS-1:0][LIDX-1:0] bankSrc;  // lane feeding each bank
    logic [LANES-1:0]           capEn;    // lane captures bank data (read stage)
    logic [LANES-1:0][BIDX-1:0] capBank;  // bank each capturing lane reads
  } strobe_t;
endpackage

// File: rtl/spmbc_ctrl.sv
module spmbc_ctrl
  import spmbc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issueValid,
  input  logic                   issueStore,
  input  logic                   issueLast,
  input  logic [LANES-1:0]       laneEn,
  input  logic [LANES*BIDX-1:0]  laneBank,
  output strobe_t                stb,
  output logic                   outValid
);
  logic [BANKS-1:0]           selEn;
  logic [BANKS-1:0][LIDX-1:0] selSrc;
  logic [LANES-1:0]           capEnQ;
  logic [LANES-1:0][BIDX-1:0] capBankQ;
  logic                       doneQ;
  logic                       outValidQ;

  // input crossbar select: lowest enabled lane naming a bank feeds it
  always_comb begin
    selEn  = '0;
    selSrc = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int l = LANES - 1; l >= 0; l--) begin
        if (issueValid && laneEn[l] && laneBank[l*BIDX +: BIDX] == BIDX'(b)) begin
          selEn[b]  = 1'b1;
          selSrc[b] = LIDX'(l);
        end
      end
    end
  end

  // read-stage alignment registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capEnQ    <= '0;
      capBankQ  <= '0;
      doneQ     <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      capEnQ    <= laneEn & {LANES{issueValid & ~issueStore}};
      for (int l = 0; l < LANES; l++) capBankQ[l] <= laneBank[l*BIDX +: BIDX];
      doneQ     <= issueValid & issueLast;
      outValidQ <= doneQ;
    end
  end

  always_comb begin
    stb.bankEn  = selEn;
    stb.bankWr  = selEn & {BANKS{issueStore}};
    stb.bankSrc = selSrc;
    stb.capEn   = capEnQ;
    stb.capBank = capBankQ;
  end
  assign outValid = outValidQ;

  // R3: idle or fully masked issue never touches a bank
  p_idle_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |-> stb.bankEn == '0);
  p_bank_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stb.bankEn) <= $countones(laneEn));
  // R8: a store issue never schedules a collector capture
  p_store_no_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && issueStore) |=> stb.capEn == '0);
  // R6: a valid pulse traces back to a last-marked issue two cycles before
  p_valid_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(issueValid && issueLast, 2));
endmodule

// File: rtl/spmbc_datapath.sv
module spmbc_datapath
  import spmbc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                stb,
  input  logic [LANES*OFFW-1:0]  laneOff,
  input  logic [LANES*DATAW-1:0] laneData,
  input  logic [LANES*BYTES-1:0] laneMask,
  output logic [LANES*DATAW-1:0] outData
);
  logic [DATAW-1:0] bankRd [BANKS];
  logic [DATAW-1:0] col    [LANES];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATAW-1:0] mem [DEPTH];
    logic [OFFW-1:0]  wOff;
    logic [DATAW-1:0] wData;
    logic [BYTES-1:0] wMask;
    logic [DATAW-1:0] rdQ;

    // input crossbar
    assign wOff  = laneOff [stb.bankSrc[b]*OFFW  +: OFFW];
    assign wData = laneData[stb.bankSrc[b]*DATAW +: DATAW];
    assign wMask = laneMask[stb.bankSrc[b]*BYTES +: BYTES];

    always_ff @(posedge clk) begin
      if (stb.bankEn[b]) begin
        if (stb.bankWr[b]) begin
          for (int k = 0; k < BYTES; k++)
            if (wMask[k]) mem[wOff][k*8 +: 8] <= wData[k*8 +: 8];
        end
        rdQ <= mem[wOff];
      end
    end
    assign bankRd[b] = rdQ;
  end

  // output crossbar and collector
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)             col[l] <= '0;
      else if (stb.capEn[l])  col[l] <= bankRd[stb.capBank[l]];
    end
    assign outData[l*DATAW +: DATAW] = col[l];

    // R3 / R7: an entry not captured holds its value
    p_collector_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.capEn[l] |=> $stable(col[l]));
  end
endmodule

// File: rtl/lane_bank_gather.sv
module lane_bank_gather
  import spmbc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issueValid,
  input  logic                   issueStore,
  input  logic                   issueLast,
  input  logic [LANES-1:0]       laneEn,
  input  logic [LANES*BIDX-1:0]  laneBank,
  input  logic [LANES*OFFW-1:0]  laneOff,
  input  logic [LANES*DATAW-1:0] laneData,
  input  logic [LANES*BYTES-1:0] laneMask,
  output logic                   outValid,
  output logic [LANES*DATAW-1:0] outData
);
  strobe_t stb;

  spmbc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issueValid), .issueStore(issueStore), .issueLast(issueLast),
    .laneEn(laneEn), .laneBank(laneBank),
    .stb(stb), .outValid(outValid)
  );

  spmbc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .laneOff(laneOff), .laneData(laneData), .laneMask(laneMask),
    .outData(outData)
  );

  // R2: inputs must be conflict free (shared bank implies shared offset)
  for (genvar i = 0; i < LANES; i++) begin : g_ci
    for (genvar j = i + 1; j < LANES; j++) begin : g_cj
      p_conflict_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issueValid && laneEn[i] && laneEn[j] &&
         laneBank[i*BIDX +: BIDX] == laneBank[j*BIDX +: BIDX])
        |-> laneOff[i*OFFW +: OFFW] == laneOff[j*OFFW +: OFFW]);
    end
  end
endmodule

// File: tb/lane_bank_gather_bench.sv
module lane_bank_gather_bench;
  import spmbc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issueValid = 1'b0, issueStore = 1'b0, issueLast = 1'b0;
  logic [LANES-1:0]       laneEn = '0;
  logic [LANES*BIDX-1:0]  laneBank = '0;
  logic [LANES*OFFW-1:0]  laneOff = '0;
  logic [LANES*DATAW-1:0] laneData = '0;
  logic [LANES*BYTES-1:0] laneMask = '0;
  logic                   outValid;
  logic [LANES*DATAW-1:0] outData;

  always #4 clk = ~clk;  // 125 MHz

  lane_bank_gather u_lane_bank_gather (.*);

  int checks = 0, fails = 0, cyc = 0;
  string curReq = "R9";

  // stimulus scratch
  int               bkA  [LANES];
  int               offA [LANES];
  logic [DATAW-1:0] datA [LANES];
  logic [BYTES-1:0] mskA [LANES];

  // behavioural reference
  logic [DATAW-1:0] mdl [BANKS][DEPTH];
  logic [DATAW-1:0] expCol [LANES];
  logic             expValid;
  logic             hValid, hStore, hLast;
  logic [LANES-1:0] hEn;
  logic [DATAW-1:0] hRd [LANES];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      expValid = 1'b0; hValid = 1'b0; hStore = 1'b0; hLast = 1'b0; hEn = '0;
      for (int l = 0; l < LANES; l++) begin expCol[l] = '0; hRd[l] = '0; end
    end else begin
      expValid = hValid && hLast;
      if (hValid && !hStore)
        for (int l = 0; l < LANES; l++) if (hEn[l]) expCol[l] = hRd[l];
      hValid = issueValid; hStore = issueStore; hLast = issueLast; hEn = laneEn;
      if (issueValid)
        for (int l = 0; l < LANES; l++) begin
          if (laneEn[l]) begin
            int b, o;
            b = int'(laneBank[l*BIDX +: BIDX]);
            o = int'(laneOff[l*OFFW +: OFFW]);
            if (issueStore) begin
              for (int k = 0; k < BYTES; k++)
                if (laneMask[l*BYTES + k]) mdl[b][o][k*8 +: 8] = laneData[l*DATAW + k*8 +: 8];
            end else hRd[l] = mdl[b][o];
          end
        end
    end
  end

  task automatic chk(input logic [DATAW-1:0] act, input logic [DATAW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", curReq, what, act, exp, cyc);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(DATAW'(outValid), DATAW'(expValid), "outValid");
      for (int l = 0; l < LANES; l++)
        chk(outData[l*DATAW +: DATAW], expCol[l], $sformatf("lane %0d data", l));
    end
  end

  task automatic doIssue(input logic st, input logic lst, input logic [LANES-1:0] en);
    @(negedge clk);
    issueValid = 1'b1; issueStore = st; issueLast = lst; laneEn = en;
    for (int l = 0; l < LANES; l++) begin
      laneBank[l*BIDX +: BIDX]   = BIDX'(bkA[l]);
      laneOff[l*OFFW +: OFFW]    = OFFW'(offA[l]);
      laneData[l*DATAW +: DATAW] = datA[l];
      laneMask[l*BYTES +: BYTES] = mskA[l];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      issueValid = 1'b0; laneEn = '0;
    end
  endtask

  task automatic setLanes(input int rot, input int off);
    for (int l = 0; l < LANES; l++) begin
      bkA[l] = (l + rot) % BANKS; offA[l] = off; mskA[l] = '1;
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin bkA[l] = 0; offA[l] = 0; datA[l] = '0; mskA[l] = '1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(DATAW'(outValid), '0, "reset outValid R9");
    for (int l = 0; l < LANES; l++) chk(outData[l*DATAW +: DATAW], '0, "reset data R9");
    rst_n = 1'b1;

    curReq = "R2";  // fill every entry
    for (int o = 0; o < DEPTH; o++) begin
      setLanes(0, o);
      for (int l = 0; l < LANES; l++) datA[l] = 32'hA5000000 ^ (o << 8) ^ (l * 32'h11);
      doIssue(1'b1, 1'b1, '1);
    end
    idle(2);

    curReq = "R4";  // back-to-back loads of every entry with rotated banks
    for (int o = 0; o < DEPTH; o++) begin
      setLanes(o, o);
      doIssue(1'b0, 1'b1, '1);
    end
    idle(3);

    curReq = "R1";  // partial byte masks
    setLanes(1, 3);
    mskA[0] = 4'b0001; mskA[1] = 4'b0110; mskA[2] = 4'b1000; mskA[3] = 4'b1010;
    for (int l = 0; l < LANES; l++) datA[l] = 32'hDEADBEEF + l;
    doIssue(1'b1, 1'b1, '1);
    idle(1);
    doIssue(1'b0, 1'b1, '1);
    idle(3);

    curReq = "R3";  // disabled lane in a store, then in a load
    setLanes(2, 7);
    for (int l = 0; l < LANES; l++) datA[l] = 32'h12345678 * (l + 3);
    doIssue(1'b1, 1'b1, 4'b1011);
    idle(1);
    doIssue(1'b0, 1'b1, '1);
    idle(2);
    setLanes(0, 9);
    doIssue(1'b0, 1'b1, 4'b0111);
    idle(3);

    curReq = "R5";  // broadcast
    for (int l = 0; l < LANES; l++) begin bkA[l] = 2; offA[l] = 5; end
    doIssue(1'b0, 1'b1, '1);
    idle(3);

    curReq = "R6";  // loads without the marker never pulse
    setLanes(3, 4);
    doIssue(1'b0, 1'b0, '1);
    doIssue(1'b0, 1'b0, 4'b0101);
    idle(3);

    curReq = "R7";  // one request split over two issue sets
    setLanes(0, 11);
    doIssue(1'b0, 1'b0, 4'b0011);
    setLanes(2, 12);
    doIssue(1'b0, 1'b1, 4'b1100);
    idle(3);

    curReq = "R8";  // store with marker pulses valid, collector unchanged
    setLanes(1, 13);
    for (int l = 0; l < LANES; l++) datA[l] = 32'hCAFE0000 | l;
    doIssue(1'b1, 1'b1, '1);
    idle(3);

    curReq = "R10";  // store then immediate load of the same entries
    setLanes(3, 14);
    for (int l = 0; l < LANES; l++) datA[l] = 32'h0BAD0000 ^ (l << 4);
    doIssue(1'b1, 1'b0, '1);
    doIssue(1'b0, 1'b1, '1);
    idle(3);

    curReq = "R2";  // mixed random traffic, conflict free by rotation
    for (int n = 0; n < 60; n++) begin
      int rot, off;
      rot = int'($urandom_range(BANKS - 1));
      off = int'($urandom_range(DEPTH - 1));
      setLanes(rot, off);
      for (int l = 0; l < LANES; l++) begin
        offA[l] = (off + l * 3) % DEPTH;
        datA[l] = $urandom;
        mskA[l] = BYTES'($urandom);
      end
      doIssue(1'($urandom), 1'($urandom), LANES'($urandom));
    end
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule